// File: doc/BRIEF.md
# Configurable Multiply-Accumulate Unit

This block is a parameterised multiply-accumulate datapath. Each clock it multiplies an `A_W`-bit operand by a `B_W`-bit operand and adds the product to a running sum, or subtracts it. The sum is kept in an accumulator that is 16 guard bits wider than the full product. The accumulator register drives the output directly. Each operand has its own signedness control. The accumulator can be reloaded from a preload port while the unit runs. A sticky overflow flag is updated on the same edge as the sum.

Two stages are optional and are chosen at elaboration: an operand input stage (`REG_IN`) and a product pipeline stage (`REG_PIPE`). The controls for signedness, add/subtract and load pass through the same optional stages, so they stay aligned with the product they govern. Each operand input stage can take its value from a serial input instead of the parallel port. The stage contents appear on a serial output, so a neighbouring unit can cascade from it. A clock enable freezes every register, and a synchronous reset clears them.

Top module: `mac_unit`

## Requirements
- R1: With `sub_en`=0 and `load_en`=0, the accumulator takes the old sum plus the product of the two operands, modulo 2^(A_W+B_W+16).
- R2: With `sub_en`=1 and `load_en`=0, the accumulator takes the old sum minus the product.
- R3: `sign_a`=1 treats `a_in` as two's complement, and `sign_a`=0 treats it as unsigned. `sign_b` does the same for `b_in`.
- R4: `load_en`=1 takes priority over accumulation. The accumulator takes `preload` and `ovf` clears.
- R5: When either sign control of a step is 1, the step is checked as signed; otherwise it is checked as unsigned. `ovf` sets when the exact result of an accumulate step does not fit the accumulator width under that reading. It then stays 1 until a load or a reset.
- R6: A step's result shows on `acc_out` and `ovf` after REG_IN+REG_PIPE+1 rising edges with `ce` high. All of that step's controls arrive with it.
- R7: While `ce`=0, every register holds, including `acc_out`, `ovf`, `sro_a` and `sro_b`.
- R8: With `ser_sel_a`=1, the A operand is taken from `sri_a` instead of `a_in`. `sro_a` shows the A input-stage contents: the registered value when REG_IN=1, otherwise the selected operand itself. The same holds for B.
- R9: `rst`=1 at a rising edge clears `acc_out`, `ovf` and all stage registers, whatever the value of `ce`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all registers |
| a_in | input | A_W | Parallel operand A |
| b_in | input | B_W | Parallel operand B |
| sri_a | input | A_W | Serial-chain input for operand A |
| sri_b | input | B_W | Serial-chain input for operand B |
| ser_sel_a | input | 1 | 1: operand A taken from sri_a |
| ser_sel_b | input | 1 | 1: operand B taken from sri_b |
| sign_a | input | 1 | 1: operand A is two's complement |
| sign_b | input | 1 | 1: operand B is two's complement |
| sub_en | input | 1 | 1: subtract product, 0: add |
| load_en | input | 1 | 1: load accumulator from preload |
| preload | input | A_W+B_W+16 | Value loaded into the accumulator |
| acc_out | output | A_W+B_W+16 | Accumulated sum |
| ovf | output | 1 | Sticky registered overflow flag |
| sro_a | output | A_W | Serial-chain output, operand A stage |
| sro_b | output | B_W | Serial-chain output, operand B stage |

## Verification
A step driven before a rising edge reaches `acc_out` and `ovf` on the REG_IN+REG_PIPE+1-th enabled edge. That is the third edge in the registered configuration and the first edge when both stages are bypassed. `sro_a`/`sro_b` follow one enabled edge after the inputs when the input stage exists, and at once when it does not. The bench keeps a delay line of exactly that depth in its arithmetic model. The line advances only on enabled edges, and the bench compares every output at the falling edge that follows. A registered instance and a fully bypassed instance run in parallel on the same near-exhaustive sweep of operands, signedness and add/subtract. The sweep also includes overflow, load, hold and reset episodes.

// File: rtl/mac_pkg.sv
package mac_pkg;

  // Control bundle that travels alongside the operands through every stage.
  typedef struct packed {
    logic sign_a;
    logic sign_b;
    logic sub;
    logic load;
  } mac_ctrl_t;

  localparam int unsigned CTRL_W = $bits(mac_ctrl_t);

endpackage

// File: rtl/mac_stage.sv
// Optional register stage: a plain enabled register, or a wire when REG=0.
module mac_stage #(
  parameter int unsigned W   = 8,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst)     q <= '0;
        else if (ce) q <= d;
      end

      AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(q)); // R7
    end else begin : g_wire
      logic unused_stage_ok;
      assign unused_stage_ok = ^{clk, rst, ce};
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/mac_opreg.sv
// Operand input stage with serial-chain selection and chain output.
module mac_opreg #(
  parameter int unsigned W   = 8,
  parameter bit          REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ce,
  input  logic [W-1:0] par_d,
  input  logic [W-1:0] ser_d,
  input  logic         ser_sel,
  output logic [W-1:0] q,
  output logic [W-1:0] sro
);

  logic [W-1:0] pick;   // operand chosen for this stage

  assign pick = ser_sel ? ser_d : par_d;

  mac_stage #(.W(W), .REG(REG)) u_stage (
    .clk (clk),
    .rst (rst),
    .ce  (ce),
    .d   (pick),
    .q   (q)
  );

  assign sro = q;

  generate
    if (REG) begin : g_chk
      AST_SERIAL_PICK: assert property (@(posedge clk) disable iff (rst)
        (ce && ser_sel) |=> (sro == $past(ser_d))); // R8
      AST_PARALLEL_PICK: assert property (@(posedge clk) disable iff (rst)
        (ce && !ser_sel) |=> (sro == $past(par_d))); // R8
    end
  endgenerate

endmodule

// File: rtl/mac_mult.sv
// Product generation with per-operand signedness, plus the optional pipeline
// stage that also carries the controls and preload value.
module mac_mult
  import mac_pkg::*;
#(
  parameter int unsigned A_W = 18,
  parameter int unsigned B_W = 18,
  parameter int unsigned AW  = 52,
  parameter bit          REG = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  ce,
  input  logic [A_W-1:0]        op_a,
  input  logic [B_W-1:0]        op_b,
  input  mac_ctrl_t             ctrl_in,
  input  logic [AW-1:0]         pre_in,
  output logic [A_W+B_W:0]      prod_out,
  output mac_ctrl_t             ctrl_out,
  output logic [AW-1:0]         pre_out
);

  localparam int unsigned PW   = A_W + B_W;
  localparam int unsigned XW   = PW + 2;
  localparam int unsigned BUSW = PW + 1 + CTRL_W + AW;

  // Exact product of the two operands under their own signedness, returned
  // as a PW+1-bit two's complement number (always wide enough).
  function automatic logic [PW:0] mul_ext(
    input logic [A_W-1:0] a,
    input logic [B_W-1:0] b,
    input logic           sa,
    input logic           sb
  );
    logic signed [A_W:0] ax;
    logic signed [B_W:0] bx;
    logic signed [XW-1:0] full;
    ax   = $signed({sa & a[A_W-1], a});
    bx   = $signed({sb & b[B_W-1], b});
    full = XW'(ax) * XW'(bx);
    return full[PW:0];
  endfunction

  logic [PW:0]     prod_now;
  logic [BUSW-1:0] bus_d;
  logic [BUSW-1:0] bus_q;

  assign prod_now = mul_ext(op_a, op_b, ctrl_in.sign_a, ctrl_in.sign_b);
  assign bus_d    = {prod_now, ctrl_in, pre_in};

  mac_stage #(.W(BUSW), .REG(REG)) u_pipe (
    .clk (clk),
    .rst (rst),
    .ce  (ce),
    .d   (bus_d),
    .q   (bus_q)
  );

  assign prod_out = bus_q[BUSW-1 -: PW+1];
  assign ctrl_out = bus_q[AW +: CTRL_W];
  assign pre_out  = bus_q[AW-1:0];

  // An all-unsigned product can never be negative.
  always_comb begin
    if (!ctrl_in.sign_a && !ctrl_in.sign_b)
      AST_UNSIGNED_PROD_POS: assert (prod_now[PW] == 1'b0); // R3
  end

endmodule

// File: rtl/mac_accum.sv
// Accumulator (always registered) with load priority and sticky overflow.
module mac_accum
  import mac_pkg::*;
#(
  parameter int unsigned PW = 36,
  parameter int unsigned AW = 52
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce,
  input  logic [PW:0]   prod,
  input  mac_ctrl_t     ctrl,
  input  logic [AW-1:0] preload,
  output logic [AW-1:0] acc,
  output logic          ovf
);

  typedef struct packed {
    logic          ov;
    logic [AW-1:0] sum;
  } step_t;

  // One accumulate step, computed two bits wider than the accumulator so
  // that the exact result is visible for the overflow decision.
  function automatic step_t acc_step(
    input logic [AW-1:0] cur,
    input logic [PW:0]   p,
    input logic          signed_mode,
    input logic          subtract
  );
    logic [AW+1:0] base;
    logic [AW+1:0] px;
    logic [AW+1:0] r;
    step_t         s;
    base = signed_mode ? {{2{cur[AW-1]}}, cur} : {2'b00, cur};
    px   = {{(AW+1-PW){p[PW]}}, p};
    r    = subtract ? (base - px) : (base + px);
    if (signed_mode)
      s.ov = !((r[AW+1:AW-1] == 3'b000) || (r[AW+1:AW-1] == 3'b111));
    else
      s.ov = (r[AW+1:AW] != 2'b00);
    s.sum = r[AW-1:0];
    return s;
  endfunction

  step_t step_now;
  logic  step_ovf;     // this step would overflow (event wire)
  logic  load_hit;     // a load is being applied this edge (event wire)

  assign step_now = acc_step(acc, prod, ctrl.sign_a | ctrl.sign_b, ctrl.sub);
  assign step_ovf = step_now.ov;
  assign load_hit = ce & ctrl.load;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      ovf <= 1'b0;
    end else if (ce) begin
      if (ctrl.load) begin
        acc <= preload;
        ovf <= 1'b0;
      end else begin
        acc <= step_now.sum;
        ovf <= ovf | step_ovf;
      end
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (acc == '0 && !ovf)); // R9
  AST_LOAD_TAKES_PRELOAD: assert property (@(posedge clk) disable iff (rst)
    load_hit |=> (acc == $past(preload) && !ovf)); // R4
  AST_HOLD_ON_CE_LOW: assert property (@(posedge clk) disable iff (rst)
    !ce |=> ($stable(acc) && $stable(ovf))); // R7
  AST_OVF_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    (ce && !ctrl.load && step_ovf) |=> ovf); // R5
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ce && !ctrl.load && ovf) |=> ovf); // R5
  AST_OVF_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (ce && !ctrl.load && !ovf && !step_ovf) |=> !ovf); // R5

endmodule

// File: rtl/mac_unit.sv
// Configurable multiply-accumulate unit: top level.
module mac_unit
  import mac_pkg::*;
#(
  parameter int unsigned A_W      = 18,
  parameter int unsigned B_W      = 18,
  parameter int unsigned GUARD    = 16,
  parameter bit          REG_IN   = 1'b1,
  parameter bit          REG_PIPE = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       ce,
  input  logic [A_W-1:0]             a_in,
  input  logic [B_W-1:0]             b_in,
  input  logic [A_W-1:0]             sri_a,
  input  logic [B_W-1:0]             sri_b,
  input  logic                       ser_sel_a,
  input  logic                       ser_sel_b,
  input  logic                       sign_a,
  input  logic                       sign_b,
  input  logic                       sub_en,
  input  logic                       load_en,
  input  logic [A_W+B_W+GUARD-1:0]   preload,
  output logic [A_W+B_W+GUARD-1:0]   acc_out,
  output logic                       ovf,
  output logic [A_W-1:0]             sro_a,
  output logic [B_W-1:0]             sro_b
);

  localparam int unsigned PW = A_W + B_W;
  localparam int unsigned AW = PW + GUARD;

  mac_ctrl_t       ctrl_raw;
  logic [CTRL_W-1:0] ctrl_s1_bits;
  mac_ctrl_t       ctrl_s1;
  mac_ctrl_t       ctrl_s2;
  logic [A_W-1:0]  op_a_s1;
  logic [B_W-1:0]  op_b_s1;
  logic [AW-1:0]   pre_s1;
  logic [AW-1:0]   pre_s2;
  logic [PW:0]     prod_s2;

  assign ctrl_raw = '{sign_a: sign_a, sign_b: sign_b, sub: sub_en, load: load_en};

  // Stage 1: operand input registers (optional) with serial chain.
  mac_opreg #(.W(A_W), .REG(REG_IN)) u_opreg_a (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .par_d   (a_in),
    .ser_d   (sri_a),
    .ser_sel (ser_sel_a),
    .q       (op_a_s1),
    .sro     (sro_a)
  );

  mac_opreg #(.W(B_W), .REG(REG_IN)) u_opreg_b (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .par_d   (b_in),
    .ser_d   (sri_b),
    .ser_sel (ser_sel_b),
    .q       (op_b_s1),
    .sro     (sro_b)
  );

  mac_stage #(.W(CTRL_W), .REG(REG_IN)) u_ctrl_s1 (
    .clk (clk),
    .rst (rst),
    .ce  (ce),
    .d   (ctrl_raw),
    .q   (ctrl_s1_bits)
  );
  assign ctrl_s1 = ctrl_s1_bits;

  mac_stage #(.W(AW), .REG(REG_IN)) u_pre_s1 (
    .clk (clk),
    .rst (rst),
    .ce  (ce),
    .d   (preload),
    .q   (pre_s1)
  );

  // Stage 2: multiplier with optional pipeline register.
  mac_mult #(.A_W(A_W), .B_W(B_W), .AW(AW), .REG(REG_PIPE)) u_mult (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .op_a     (op_a_s1),
    .op_b     (op_b_s1),
    .ctrl_in  (ctrl_s1),
    .pre_in   (pre_s1),
    .prod_out (prod_s2),
    .ctrl_out (ctrl_s2),
    .pre_out  (pre_s2)
  );

  // Stage 3: accumulator, always registered.
  mac_accum #(.PW(PW), .AW(AW)) u_accum (
    .clk     (clk),
    .rst     (rst),
    .ce      (ce),
    .prod    (prod_s2),
    .ctrl    (ctrl_s2),
    .preload (pre_s2),
    .acc     (acc_out),
    .ovf     (ovf)
  );

endmodule

// File: tb/mac_unit_tb.sv
module mac_unit_tb;

  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned A_W = 3;
  localparam int unsigned B_W = 3;
  localparam int unsigned AW  = A_W + B_W + 16;
  localparam int unsigned LAT = 3;  // REG_IN + REG_PIPE + 1

  typedef struct packed {
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    logic           sa;
    logic           sb;
    logic           sub;
    logic           ld;
    logic [AW-1:0]  pre;
  } ent_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce  = 1'b1;
  logic [A_W-1:0] a_i = '0, sri_a_i = '0;
  logic [B_W-1:0] b_i = '0, sri_b_i = '0;
  logic sel_a = 0, sel_b = 0, sa = 0, sb = 0, sub = 0, ld = 0;
  logic [AW-1:0] pre = '0;

  logic [AW-1:0]  acc_r, acc_b;
  logic           ovf_r, ovf_b;
  logic [A_W-1:0] sro_a_r, sro_a_b;
  logic [B_W-1:0] sro_b_r, sro_b_b;

  int unsigned n_chk  = 0;
  int unsigned n_fail = 0;
  string       tag    = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit #(.A_W(A_W), .B_W(B_W), .GUARD(16), .REG_IN(1'b1), .REG_PIPE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .ce(ce), .a_in(a_i), .b_in(b_i),
    .sri_a(sri_a_i), .sri_b(sri_b_i), .ser_sel_a(sel_a), .ser_sel_b(sel_b),
    .sign_a(sa), .sign_b(sb), .sub_en(sub), .load_en(ld), .preload(pre),
    .acc_out(acc_r), .ovf(ovf_r), .sro_a(sro_a_r), .sro_b(sro_b_r)
  );

  mac_unit #(.A_W(A_W), .B_W(B_W), .GUARD(16), .REG_IN(1'b0), .REG_PIPE(1'b0)) u_dut_byp (
    .clk(clk), .rst(rst), .ce(ce), .a_in(a_i), .b_in(b_i),
    .sri_a(sri_a_i), .sri_b(sri_b_i), .ser_sel_a(sel_a), .ser_sel_b(sel_b),
    .sign_a(sa), .sign_b(sb), .sub_en(sub), .load_en(ld), .preload(pre),
    .acc_out(acc_b), .ovf(ovf_b), .sro_a(sro_a_b), .sro_b(sro_b_b)
  );

  // Bench model state
  ent_t           line [LAT];
  logic [AW-1:0]  m_acc = '0, k_acc = '0;
  logic           m_ovf = 1'b0, k_ovf = 1'b0;
  logic [A_W-1:0] m_sro_a = '0;
  logic [B_W-1:0] m_sro_b = '0;

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Arithmetic reading of one step (R1 R2 R3 R4 R5).
  task automatic apply(inout logic [AW-1:0] acc, inout logic ov, input ent_t e);
    longint av, bv, prod, base, r;
    bit sm, on;
    if (e.ld) begin
      acc = e.pre;
      ov  = 1'b0;
    end else begin
      av = longint'(e.a); if (e.sa && e.a[A_W-1]) av -= (longint'(1) << A_W);
      bv = longint'(e.b); if (e.sb && e.b[B_W-1]) bv -= (longint'(1) << B_W);
      prod = av * bv;
      sm   = e.sa | e.sb;
      base = longint'(acc);
      if (sm && acc[AW-1]) base -= (longint'(1) << AW);
      r = e.sub ? (base - prod) : (base + prod);
      if (sm) on = (r > ((longint'(1) << (AW-1)) - 1)) || (r < -(longint'(1) << (AW-1)));
      else    on = (r < 0) || (r >= (longint'(1) << AW));
      acc = AW'(r);
      ov  = ov | on;
    end
  endtask

  task automatic tick();
    ent_t e;
    e.a = sel_a ? sri_a_i : a_i;
    e.b = sel_b ? sri_b_i : b_i;
    e.sa = sa; e.sb = sb; e.sub = sub; e.ld = ld; e.pre = pre;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < LAT; i++) line[i] = '0;
      m_acc = '0; m_ovf = 1'b0; k_acc = '0; k_ovf = 1'b0;
      m_sro_a = '0; m_sro_b = '0;
    end else if (ce) begin
      for (int i = LAT-1; i > 0; i--) line[i] = line[i-1];
      line[0] = e;
      apply(m_acc, m_ovf, line[LAT-1]);
      apply(k_acc, k_ovf, e);
      m_sro_a = e.a; m_sro_b = e.b;
    end
    @(negedge clk);
    // R6: registered instance lags by LAT edges, bypassed one by a single edge
    chk("acc_out (R6 registered)", 64'(acc_r), 64'(m_acc));
    chk("ovf (R5 registered)", 64'(ovf_r), 64'(m_ovf));
    chk("acc_out (R6 bypassed)", 64'(acc_b), 64'(k_acc));
    chk("ovf (R5 bypassed)", 64'(ovf_b), 64'(k_ovf));
    chk("sro_a (R8 registered)", 64'(sro_a_r), 64'(m_sro_a));
    chk("sro_b (R8 registered)", 64'(sro_b_r), 64'(m_sro_b));
    chk("sro_a (R8 bypassed)", 64'(sro_a_b), 64'(sel_a ? sri_a_i : a_i));
    chk("sro_b (R8 bypassed)", 64'(sro_b_b), 64'(sel_b ? sri_b_i : b_i));
  endtask

  task automatic idle(input int n);
    a_i = '0; b_i = '0; sel_a = 0; sel_b = 0; ld = 0; sub = 0; ce = 1;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < LAT; i++) line[i] = '0;
    @(negedge clk);
    // R9: reset state
    tag = "R9";
    rst = 1; a_i = 3'd5; b_i = 3'd6; ld = 1; pre = 22'h12345;
    tick(); tick();
    rst = 0; ld = 0;
    idle(LAT);

    // R1 R2 R3 sweep: every operand pair, signedness and direction
    tag = "R1 R2 R3";
    for (int s = 0; s < 8; s++) begin
      for (int ab = 0; ab < 64; ab++) begin
        sa = s[0]; sb = s[1]; sub = s[2];
        a_i = 3'(ab); b_i = 3'(ab >> 3);
        sel_a = 0; sel_b = 0; ld = 0; ce = 1;
        if (ab % 17 == 0) begin
          ld = 1; pre = 22'($urandom);
        end
        tick();
      end
    end
    ld = 0;
    idle(LAT);

    // R7: clock enable low, with stimulus that would otherwise change state
    tag = "R7";
    sa = 0; sb = 0; sub = 0; a_i = 3'd7; b_i = 3'd7; ld = 0;
    tick(); tick();
    ce = 0;
    for (int i = 0; i < 6; i++) begin
      a_i = 3'(i); b_i = 3'(7 - i); ld = (i % 2 == 1); pre = 22'($urandom);
      sel_a = 1; sri_a_i = 3'(i + 2);
      tick();
    end
    ce = 1; ld = 0; sel_a = 0;
    idle(LAT);

    // R8: serial inputs selected, random enable gaps
    tag = "R8";
    for (int i = 0; i < 200; i++) begin
      sel_a = i[0]; sel_b = i[1];
      sri_a_i = 3'($urandom); sri_b_i = 3'($urandom);
      a_i = 3'($urandom); b_i = 3'($urandom);
      sa = i[2]; sb = i[3]; sub = i[4];
      ld = (i % 29 == 0); pre = 22'($urandom);
      ce = ($urandom % 6) != 0;
      tick();
    end
    idle(LAT);

    // R5: signed positive overflow, then sticky
    tag = "R5";
    ld = 1; pre = 22'h1FFFFC; tick(); ld = 0;
    sa = 1; sb = 1; a_i = 3'd3; b_i = 3'd3; tick();
    idle(LAT + 3);
    // R4: load clears the flag
    tag = "R4";
    ld = 1; pre = 22'h200003; tick(); ld = 0;
    idle(LAT);
    // R5: signed negative overflow (-4 * 3 below the minimum)
    tag = "R5";
    sa = 1; sb = 1; a_i = 3'b100; b_i = 3'd3; tick();
    idle(LAT + 2);
    // R5: unsigned overflow at the top and underflow at zero
    tag = "R4";
    ld = 1; pre = 22'h3FFFF0; tick(); ld = 0;
    tag = "R5";
    sa = 0; sb = 0; a_i = 3'd7; b_i = 3'd7; tick();
    idle(LAT + 1);
    tag = "R4";
    ld = 1; pre = 22'h000002; tick(); ld = 0;
    tag = "R5";
    sa = 0; sb = 0; sub = 1; a_i = 3'd1; b_i = 3'd3; tick();
    idle(LAT + 1);

    // R9: reset wins over ce low
    tag = "R9";
    ce = 0; rst = 1; tick(); rst = 0; ce = 1;
    idle(LAT);

    summary();
    $finish;
  end

endmodule